// File: doc/BRIEF.md
# Superslice Dispatch Slot Allocator

This block places one decoded group of up to `GROUP` (default six) micro-ops per cycle onto a back end of four execution slices. The slices form two superslices, and each superslice pairs an even slice with an odd slice. Every slice has its own dedicated port. Each superslice also has one shared port, which may deliver an op to either of its slices. Branch ops take a separate path with two branch ports and never touch execution-slice resources.

Each op carries a class code and a count of primary source operands. Ops are placed strictly in program order. Each placed op gets a grant: a valid bit, a branch flag, a 2-bit slice index (or branch port index) and a flag that marks use of a shared port. The first op that cannot be placed is stalled, together with every younger valid op of the group, so upstream can present them again next cycle. All results are registered.

Top module: `ssd_dispatch_alloc`

## Requirements
- R1: While `rst` is high at a clock edge, every grant output, `stall_mask` and `stall` read zero after that edge.
- R2: A normal op (class 0, also codes 6 and 7) takes the first free dedicated port among slices 0, 1, 2 and 3 whose slice still has room. Failing that, it takes the shared port of superslice 0 and then of superslice 1, landing on the lower-numbered slice of that superslice with room. At most one op uses each shared port per cycle.
- R3: A shared port accepts only ops with at most two primary sources (`op_nsrc` ≤ 2). An op with three sources can use dedicated ports only.
- R4: When an op cannot be placed, it and every younger valid op of the group get a stall bit and no grant, and `stall` is high. Older ops keep their grants.
- R5: Branch ops (class 5) take branch port 0 and then port 1, reported with `gnt_br`=1 and the port number in `gnt_idx`. A third branch in one group stalls. Branch ops consume no execution-slice port.
- R6: An even-only op (class 2) goes to the even slice of the first superslice whose even and odd dedicated ports are both free, and it uses up both of those ports.
- R7: Two consecutive paired ops (class 3) form a pair. The older one goes to the even slice and the younger one to the odd slice of the same superslice, both through dedicated ports. A pair head whose next op is not a valid paired op stalls.
- R8: A vector op (class 1) uses one port (the even dedicated port, then the odd dedicated port, then the shared port) and adds load to both slices of its superslice. The reported index is the slice of the dedicated port used, or the even slice for the shared port.
- R9: A tuple-restricted op (class 4) is placed only where each slice of its superslice then holds at most one op. After it is placed, that superslice takes no second op into either slice in the same cycle.
- R10: No slice receives more than two ops in one cycle, counting vector ops on both slices.
- R11: An op with `op_vld` low gets neither a grant nor a stall and consumes no resource.
- R12: Results appear one clock after the group is presented. Each group is placed with all resources free, independent of earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | GROUP | Per-op valid, bit i = op i (op 0 oldest) |
| op_cls | input | 3*GROUP | Per-op class code: 0 normal, 1 vector, 2 even-only, 3 paired, 4 tuple-restricted, 5 branch |
| op_nsrc | input | 2*GROUP | Per-op count of primary sources |
| gnt_vld | output | GROUP | Op i placed |
| gnt_br | output | GROUP | Op i went to a branch port |
| gnt_idx | output | 2*GROUP | Slice index, or branch port index |
| gnt_shr | output | GROUP | Op i used a shared superslice port |
| stall_mask | output | GROUP | Op i held back to the next cycle |
| stall | output | 1 | At least one op of the group stalled |

## Verification
Placement is a pure function of the group presented at one clock edge, and every output is registered. The grants, the stall mask and the stall flag for a group are therefore all due one edge after the group is driven. The bench drives each group on a falling edge and compares all outputs on the next falling edge, with exactly one rising edge in between. Nothing is carried between groups, so each scenario checks one group in isolation. The reset checks sample on the falling edge after a rising edge taken with reset high.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int NUM_SS      = 2;
  localparam int NUM_SLICE   = 2 * NUM_SS;
  localparam int SLICE_W     = $clog2(NUM_SLICE);
  localparam int BR_PORTS    = 2;
  localparam int BR_W        = $clog2(BR_PORTS + 1);
  localparam int SLICE_CAP   = 2;
  localparam int LOAD_W      = $clog2(SLICE_CAP + 1);
  localparam int SHR_MAX_SRC = 2;
  localparam int CLS_W       = 3;
  localparam int SRC_W       = 2;

  localparam logic [CLS_W-1:0] CLS_VEC   = 3'd1;
  localparam logic [CLS_W-1:0] CLS_EVEN  = 3'd2;
  localparam logic [CLS_W-1:0] CLS_PAIR  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_TUPLE = 3'd4;
  localparam logic [CLS_W-1:0] CLS_BR    = 3'd5;

  typedef struct packed {
    logic vld;
    logic br;
    logic is_vec;
    logic is_even;
    logic is_pair;
    logic is_tup;
    logic shr_ok;
  } op_t;

  typedef struct packed {
    logic               vld;
    logic               br;
    logic [SLICE_W-1:0] idx;
    logic               shr;
  } gnt_t;

  typedef struct packed {
    logic [NUM_SLICE-1:0]             ded;
    logic [NUM_SS-1:0]                shr;
    logic [NUM_SLICE-1:0][LOAD_W-1:0] load;
    logic [NUM_SS-1:0]                lock;
    logic [BR_W-1:0]                  brc;
    logic                             stopped;
    logic                             tail_pend;
    logic [SLICE_W-1:0]               tail_idx;
  } rsc_t;
endpackage

// File: rtl/ssd_op_decode.sv
module ssd_op_decode
  import ssd_pkg::*;
(
  input  logic             vld,
  input  logic [CLS_W-1:0] cls,
  input  logic [SRC_W-1:0] nsrc,
  output op_t              op
);
  always_comb begin
    op         = '0;
    op.vld     = vld;
    op.br      = (cls == CLS_BR);
    op.is_vec  = (cls == CLS_VEC);
    op.is_even = (cls == CLS_EVEN);
    op.is_pair = (cls == CLS_PAIR);
    op.is_tup  = (cls == CLS_TUPLE);
    op.shr_ok  = (nsrc <= SRC_W'(SHR_MAX_SRC));
  end
endmodule

// File: rtl/ssd_place_stage.sv
module ssd_place_stage
  import ssd_pkg::*;
(
  input  op_t  op,
  input  logic nxt_pair,
  input  rsc_t st_i,
  output rsc_t st_o,
  output gnt_t gnt,
  output logic stall
);
  // room left on a slice, narrowed to one op when its superslice is locked
  function automatic logic fits(input rsc_t s, input int sl);
    logic [LOAD_W-1:0] cap;
    cap = s.lock[sl / 2] ? LOAD_W'(1) : LOAD_W'(SLICE_CAP);
    return s.load[sl] < cap;
  endfunction

  logic found;

  always_comb begin
    st_o  = st_i;
    gnt   = '0;
    stall = 1'b0;
    found = 1'b0;
    if (op.vld) begin
      if (st_i.stopped) begin
        found = 1'b0;
      end else if (st_i.tail_pend) begin
        // younger half of a pair: resources were taken by its head
        gnt.vld        = 1'b1;
        gnt.idx        = st_i.tail_idx;
        st_o.tail_pend = 1'b0;
        found          = 1'b1;
      end else if (op.br) begin
        if (st_i.brc < BR_W'(BR_PORTS)) begin
          gnt.vld  = 1'b1;
          gnt.br   = 1'b1;
          gnt.idx  = SLICE_W'(st_i.brc);
          st_o.brc = st_i.brc + BR_W'(1);
          found    = 1'b1;
        end
      end else if (op.is_vec) begin
        for (int ss = 0; ss < NUM_SS; ss++) begin
          if (!found && fits(st_i, 2*ss) && fits(st_i, 2*ss+1)) begin
            if (!st_i.ded[2*ss]) begin
              st_o.ded[2*ss] = 1'b1;
              gnt.idx        = SLICE_W'(2*ss);
              found          = 1'b1;
            end else if (!st_i.ded[2*ss+1]) begin
              st_o.ded[2*ss+1] = 1'b1;
              gnt.idx          = SLICE_W'(2*ss+1);
              found            = 1'b1;
            end else if (op.shr_ok && !st_i.shr[ss]) begin
              st_o.shr[ss] = 1'b1;
              gnt.idx      = SLICE_W'(2*ss);
              gnt.shr      = 1'b1;
              found        = 1'b1;
            end
            if (found) begin
              gnt.vld            = 1'b1;
              st_o.load[2*ss]    = st_i.load[2*ss] + LOAD_W'(1);
              st_o.load[2*ss+1]  = st_i.load[2*ss+1] + LOAD_W'(1);
            end
          end
        end
      end else if (op.is_even) begin
        for (int ss = 0; ss < NUM_SS; ss++) begin
          if (!found && !st_i.ded[2*ss] && !st_i.ded[2*ss+1] && fits(st_i, 2*ss)) begin
            st_o.ded[2*ss]   = 1'b1;
            st_o.ded[2*ss+1] = 1'b1;
            st_o.load[2*ss]  = st_i.load[2*ss] + LOAD_W'(1);
            gnt.vld          = 1'b1;
            gnt.idx          = SLICE_W'(2*ss);
            found            = 1'b1;
          end
        end
      end else if (op.is_pair) begin
        if (nxt_pair) begin
          for (int ss = 0; ss < NUM_SS; ss++) begin
            if (!found && !st_i.ded[2*ss] && !st_i.ded[2*ss+1] &&
                fits(st_i, 2*ss) && fits(st_i, 2*ss+1)) begin
              st_o.ded[2*ss]    = 1'b1;
              st_o.ded[2*ss+1]  = 1'b1;
              st_o.load[2*ss]   = st_i.load[2*ss] + LOAD_W'(1);
              st_o.load[2*ss+1] = st_i.load[2*ss+1] + LOAD_W'(1);
              st_o.tail_pend    = 1'b1;
              st_o.tail_idx     = SLICE_W'(2*ss+1);
              gnt.vld           = 1'b1;
              gnt.idx           = SLICE_W'(2*ss);
              found             = 1'b1;
            end
          end
        end
      end else if (op.is_tup) begin
        for (int ss = 0; ss < NUM_SS; ss++) begin
          for (int k = 0; k < 2; k++) begin
            if (!found && st_i.load[2*ss+k] == '0 &&
                st_i.load[2*ss+1-k] <= LOAD_W'(1)) begin
              if (!st_i.ded[2*ss+k]) begin
                st_o.ded[2*ss+k] = 1'b1;
                found            = 1'b1;
              end else if (op.shr_ok && !st_i.shr[ss]) begin
                st_o.shr[ss] = 1'b1;
                gnt.shr      = 1'b1;
                found        = 1'b1;
              end
              if (found) begin
                gnt.vld           = 1'b1;
                gnt.idx           = SLICE_W'(2*ss+k);
                st_o.load[2*ss+k] = LOAD_W'(1);
                st_o.lock[ss]     = 1'b1;
              end
            end
          end
        end
      end else begin
        for (int s = 0; s < NUM_SLICE; s++) begin
          if (!found && !st_i.ded[s] && fits(st_i, s)) begin
            st_o.ded[s]  = 1'b1;
            st_o.load[s] = st_i.load[s] + LOAD_W'(1);
            gnt.vld      = 1'b1;
            gnt.idx      = SLICE_W'(s);
            found        = 1'b1;
          end
        end
        if (!found && op.shr_ok) begin
          for (int ss = 0; ss < NUM_SS; ss++) begin
            for (int k = 0; k < 2; k++) begin
              if (!found && !st_i.shr[ss] && fits(st_i, 2*ss+k)) begin
                st_o.shr[ss]      = 1'b1;
                st_o.load[2*ss+k] = st_i.load[2*ss+k] + LOAD_W'(1);
                gnt.vld           = 1'b1;
                gnt.shr           = 1'b1;
                gnt.idx           = SLICE_W'(2*ss+k);
                found             = 1'b1;
              end
            end
          end
        end
      end
      if (!found) begin
        stall        = 1'b1;
        st_o.stopped = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssd_dispatch_alloc.sv
module ssd_dispatch_alloc
  import ssd_pkg::*;
#(
  parameter int GROUP = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [GROUP-1:0]           op_vld,
  input  logic [GROUP*CLS_W-1:0]     op_cls,
  input  logic [GROUP*SRC_W-1:0]     op_nsrc,
  output logic [GROUP-1:0]           gnt_vld,
  output logic [GROUP-1:0]           gnt_br,
  output logic [GROUP*SLICE_W-1:0]   gnt_idx,
  output logic [GROUP-1:0]           gnt_shr,
  output logic [GROUP-1:0]           stall_mask,
  output logic                       stall
);
  op_t              ops   [GROUP];
  rsc_t             chain [GROUP+1];
  gnt_t             gnt_c [GROUP];
  logic [GROUP-1:0] stall_c;
  logic [GROUP-1:0] nxt_pair;

  assign chain[0] = '0;

  for (genvar i = 0; i < GROUP; i++) begin : g_op
    ssd_op_decode u_dec (
      .vld  (op_vld[i]),
      .cls  (op_cls[i*CLS_W +: CLS_W]),
      .nsrc (op_nsrc[i*SRC_W +: SRC_W]),
      .op   (ops[i])
    );
  end

  for (genvar i = 0; i < GROUP; i++) begin : g_nxt
    if (i == GROUP - 1) begin : g_last
      assign nxt_pair[i] = 1'b0;
    end else begin : g_mid
      assign nxt_pair[i] = ops[i+1].vld & ops[i+1].is_pair;
    end
  end

  for (genvar i = 0; i < GROUP; i++) begin : g_stage
    ssd_place_stage u_stage (
      .op       (ops[i]),
      .nxt_pair (nxt_pair[i]),
      .st_i     (chain[i]),
      .st_o     (chain[i+1]),
      .gnt      (gnt_c[i]),
      .stall    (stall_c[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld    <= '0;
      gnt_br     <= '0;
      gnt_idx    <= '0;
      gnt_shr    <= '0;
      stall_mask <= '0;
      stall      <= 1'b0;
    end else begin
      for (int i = 0; i < GROUP; i++) begin
        gnt_vld[i]                   <= gnt_c[i].vld;
        gnt_br[i]                    <= gnt_c[i].br;
        gnt_idx[i*SLICE_W +: SLICE_W] <= gnt_c[i].idx;
        gnt_shr[i]                   <= gnt_c[i].shr;
      end
      stall_mask <= stall_c;
      stall      <= |stall_c;
    end
  end

  // ---------------- assertions ----------------
  logic [NUM_SS-1:0][GROUP-1:0] shr_hit;
  always_comb begin
    shr_hit = '0;
    for (int s = 0; s < NUM_SS; s++)
      for (int i = 0; i < GROUP; i++)
        shr_hit[s][i] = gnt_vld[i] & gnt_shr[i] & ~gnt_br[i] &
                        (int'(gnt_idx[i*SLICE_W +: SLICE_W]) / 2 == s);
  end

  for (genvar s = 0; s < NUM_SS; s++) begin : g_ast_ss
    AST_SHR_ONE_PER_SS: assert property (@(posedge clk) disable iff (rst)
      $countones(shr_hit[s]) <= 1); // R2
  end

  AST_BR_PORT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt_vld & gnt_br) <= BR_PORTS); // R5

  for (genvar i = 0; i < GROUP; i++) begin : g_ast_op
    AST_SHR_SRC_LIMIT: assert property (@(posedge clk) disable iff (rst)
      gnt_vld[i] && gnt_shr[i] |-> $past(op_nsrc[i*SRC_W +: SRC_W]) <= SRC_W'(SHR_MAX_SRC)); // R3
    AST_IDLE_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
      !$past(op_vld[i]) |-> !gnt_vld[i] && !stall_mask[i]); // R11
    AST_GNT_NOT_STALLED: assert property (@(posedge clk) disable iff (rst)
      !(gnt_vld[i] && stall_mask[i])); // R4
    if (i < GROUP - 1) begin : g_ord
      AST_STALL_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        stall_mask[i] && $past(op_vld[i+1]) |-> stall_mask[i+1]); // R4
    end
  end
endmodule

// File: tb/test_ssd_dispatch_alloc.sv
module test_ssd_dispatch_alloc;
  localparam int G = 6;
  localparam int NORM = 0, VEC = 1, EVEN = 2, PAIR = 3, TUP = 4, BR = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [G-1:0]   op_vld  = '0;
  logic [G*3-1:0] op_cls  = '0;
  logic [G*2-1:0] op_nsrc = '0;
  logic [G-1:0]   gnt_vld, gnt_br, gnt_shr, stall_mask;
  logic [G*2-1:0] gnt_idx;
  logic           stall;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ssd_dispatch_alloc #(.GROUP(G)) i_ssd_dispatch_alloc (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_cls(op_cls), .op_nsrc(op_nsrc),
    .gnt_vld(gnt_vld), .gnt_br(gnt_br), .gnt_idx(gnt_idx), .gnt_shr(gnt_shr),
    .stall_mask(stall_mask), .stall(stall)
  );

  task automatic clear_ops();
    op_vld = '0; op_cls = '0; op_nsrc = '0;
  endtask

  task automatic put(int i, int c, int n);
    op_vld[i]        = 1'b1;
    op_cls[i*3 +: 3]  = 3'(c);
    op_nsrc[i*2 +: 2] = 2'(n);
  endtask

  task automatic fire();
    @(negedge clk);
  endtask

  // expected: valid, branch, index, shared, stalled
  task automatic chk(int i, bit v, bit b, int idx, bit s, bit st, string req);
    logic [5:0] got, exp;
    got = {gnt_vld[i], gnt_br[i], gnt_idx[i*2 +: 2], gnt_shr[i], stall_mask[i]};
    exp = {v, b, 2'(idx), s, st};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op%0d {vld,br,idx,shr,stall} got %b expected %b", req, i, got, exp);
    end
  endtask

  task automatic chk_stall(bit e, string req);
    checks++;
    if (stall !== e) begin
      fails++;
      $display("FAIL %s stall got %b expected %b", req, stall, e);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < G; i++) put(i, NORM, 1);
    @(negedge clk);
    for (int i = 0; i < G; i++) chk(i, 0, 0, 0, 0, 0, "R1");
    chk_stall(0, "R1");
    rst = 1'b0;
  endtask

  task automatic t_normal();
    clear_ops();
    for (int i = 0; i < G; i++) put(i, NORM, 2);
    fire();
    for (int i = 0; i < 4; i++) chk(i, 1, 0, i, 0, 0, "R2");
    chk(4, 1, 0, 0, 1, 0, "R2");
    chk(5, 1, 0, 2, 1, 0, "R2");
    chk_stall(0, "R2");
  endtask

  task automatic t_src_limit();
    clear_ops();
    for (int i = 0; i < G; i++) put(i, NORM, 3);
    fire();
    for (int i = 0; i < 4; i++) chk(i, 1, 0, i, 0, 0, "R3");
    chk(4, 0, 0, 0, 0, 1, "R3");
    chk(5, 0, 0, 0, 0, 1, "R4");
    chk_stall(1, "R4");
  endtask

  task automatic t_branch();
    clear_ops();
    put(0, BR, 1); put(1, BR, 1); put(2, BR, 1);
    put(3, NORM, 1); put(4, NORM, 1); put(5, NORM, 1);
    fire();
    chk(0, 1, 1, 0, 0, 0, "R5");
    chk(1, 1, 1, 1, 0, 0, "R5");
    chk(2, 0, 0, 0, 0, 1, "R5");
    for (int i = 3; i < G; i++) chk(i, 0, 0, 0, 0, 1, "R4");
    chk_stall(1, "R4");
    clear_ops();
    put(0, BR, 2); put(1, NORM, 2); put(2, NORM, 2);
    put(3, NORM, 2); put(4, NORM, 2); put(5, BR, 2);
    fire();
    chk(0, 1, 1, 0, 0, 0, "R5");
    for (int i = 1; i < 5; i++) chk(i, 1, 0, i - 1, 0, 0, "R5");
    chk(5, 1, 1, 1, 0, 0, "R5");
    chk_stall(0, "R12");
  endtask

  task automatic t_even();
    clear_ops();
    put(0, EVEN, 2); put(1, EVEN, 2); put(2, NORM, 2);
    fire();
    chk(0, 1, 0, 0, 0, 0, "R6");
    chk(1, 1, 0, 2, 0, 0, "R6");
    chk(2, 1, 0, 0, 1, 0, "R6");
    clear_ops();
    put(0, EVEN, 2); put(1, EVEN, 2); put(2, EVEN, 2);
    fire();
    chk(2, 0, 0, 0, 0, 1, "R6");
    chk_stall(1, "R6");
  endtask

  task automatic t_pair();
    clear_ops();
    put(0, PAIR, 2); put(1, PAIR, 2); put(2, PAIR, 2);
    put(3, PAIR, 2); put(4, NORM, 2); put(5, NORM, 2);
    fire();
    chk(0, 1, 0, 0, 0, 0, "R7");
    chk(1, 1, 0, 1, 0, 0, "R7");
    chk(2, 1, 0, 2, 0, 0, "R7");
    chk(3, 1, 0, 3, 0, 0, "R7");
    chk(4, 1, 0, 0, 1, 0, "R7");
    chk(5, 1, 0, 2, 1, 0, "R7");
    clear_ops();
    put(0, NORM, 2); put(1, PAIR, 2); put(2, PAIR, 2);
    fire();
    chk(1, 1, 0, 2, 0, 0, "R7");
    chk(2, 1, 0, 3, 0, 0, "R7");
    clear_ops();
    put(0, NORM, 2); put(1, PAIR, 2); put(2, NORM, 2);
    fire();
    chk(0, 1, 0, 0, 0, 0, "R7");
    chk(1, 0, 0, 0, 0, 1, "R7");
    chk(2, 0, 0, 0, 0, 1, "R7");
  endtask

  task automatic t_vector();
    clear_ops();
    put(0, VEC, 2); put(1, VEC, 2); put(2, VEC, 2);
    put(3, NORM, 2); put(4, NORM, 2); put(5, VEC, 2);
    fire();
    chk(0, 1, 0, 0, 0, 0, "R8");
    chk(1, 1, 0, 1, 0, 0, "R8");
    chk(2, 1, 0, 2, 0, 0, "R8");
    chk(3, 1, 0, 3, 0, 0, "R8");
    chk(4, 1, 0, 2, 1, 0, "R10");
    chk(5, 0, 0, 0, 0, 1, "R10");
    chk_stall(1, "R10");
  endtask

  task automatic t_tuple();
    clear_ops();
    put(0, TUP, 2);
    for (int i = 1; i < G; i++) put(i, NORM, 2);
    fire();
    chk(0, 1, 0, 0, 0, 0, "R9");
    chk(1, 1, 0, 1, 0, 0, "R9");
    chk(4, 1, 0, 2, 1, 0, "R9");
    chk(5, 0, 0, 0, 0, 1, "R9");
    clear_ops();
    for (int i = 0; i < 5; i++) put(i, NORM, 2);
    put(5, TUP, 2);
    fire();
    chk(4, 1, 0, 0, 1, 0, "R9");
    chk(5, 0, 0, 0, 0, 1, "R9");
  endtask

  task automatic t_holes();
    clear_ops();
    put(0, NORM, 2); put(1, BR, 2); put(2, NORM, 2);
    put(3, BR, 2); put(4, NORM, 3); put(5, BR, 2);
    op_vld[1] = 1'b0;
    op_vld[4] = 1'b0;
    fire();
    chk(0, 1, 0, 0, 0, 0, "R11");
    chk(1, 0, 0, 0, 0, 0, "R11");
    chk(2, 1, 0, 1, 0, 0, "R11");
    chk(3, 1, 1, 0, 0, 0, "R11");
    chk(4, 0, 0, 0, 0, 0, "R11");
    chk(5, 1, 1, 1, 0, 0, "R11");
    chk_stall(0, "R11");
  endtask

  task automatic t_reset_mid();
    clear_ops();
    for (int i = 0; i < G; i++) put(i, NORM, 2);
    rst = 1'b1;
    fire();
    for (int i = 0; i < G; i++) chk(i, 0, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    fire();
    chk(0, 1, 0, 0, 0, 0, "R12");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_normal();
    t_src_limit();
    t_normal();
    t_branch();
    t_even();
    t_pair();
    t_vector();
    t_tuple();
    t_holes();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule